// File: doc/BRIEF.md
# Multi-Speed I2C SCL Phase Timer

This block times the SCL clock of an I2C controller. For each request from the byte engine it drives SCL low for a programmed number of controller clocks. It then releases the line and waits until SCL is actually seen high. Only then does it count the programmed high time. Three high/low count pairs are provided: standard, fast (which also serves fast-plus with different values) and high speed. A two-bit speed field picks which pair is used.

A build parameter states whether high-speed mode exists. When it does not, a high-speed selection quietly uses the fast pair, and the high-speed counts are never read. A hold count places the SDA change strobe a set number of clocks after SCL falls. A slave that holds SCL low after release stretches the cycle, and the block flags this while it waits. Requests are START, BIT and STOP. All counts are sampled when a request is accepted.

Typical values at a 100 MHz controller clock are as follows. Standard mode needs about 400 high and 470 low (4.0/4.7 us). Fast needs 60/130 (0.6/1.3 us), fast-plus 26/50 (260/500 ns) and high speed 16/32 (160/320 ns).

Top module: `scl_phase_timer`

## Requirements
- R1: After reset, ready_o=1, scl_oe_o=0, sda_chg_o=0, done_o=0 and stretch_o=0.
- R2: speed_i selects the count pair: 1 selects standard, 2 selects fast/fast-plus, 3 selects high speed, and 0 selects standard. For a BIT request, scl_oe_o is high for exactly the selected low count of cycles, starting in the cycle after acceptance.
- R3: If nothing stretches the clock, done_o pulses for one cycle, SYNC_STAGES+1+high count cycles after scl_oe_o falls, counting the first released cycle. The block is ready in the next cycle.
- R4: hs_cap_o reports the HS_CAP parameter. With HS_CAP=0, speed_i=3 uses the fast pair.
- R5: Any selected high or low count below MIN_CNT (default 6) is treated as MIN_CNT.
- R6: For BIT and STOP, sda_chg_o pulses once during the low phase, in low cycle index min(hold, low count-1). A hold of 0 puts the pulse in the first low cycle.
- R7: High-phase counting starts only after scl_i has been seen high through the SYNC_STAGES-flop synchronizer. Each cycle SCL stays low beyond that latency adds one cycle to the high phase and one cycle of stretch_o.
- R8: For START, scl_oe_o stays 0 and sda_chg_o pulses in the first cycle after acceptance. done_o comes on the high-count-th cycle.
- R9: STOP behaves like BIT, and in addition sda_chg_o pulses together with done_o.
- R10: Counts, hold and speed are captured when a request is accepted. Changes made while the request runs do not alter its timing.
- R11: A request with op_i=0 (none) is ignored, and so is a request while ready_o=0. Neither one starts a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 2 | Speed field: 1 std, 2 fast, 3 high speed, 0 std |
| ss_hcnt_i | input | CNT_W | Standard high count |
| ss_lcnt_i | input | CNT_W | Standard low count |
| fs_hcnt_i | input | CNT_W | Fast/fast-plus high count |
| fs_lcnt_i | input | CNT_W | Fast/fast-plus low count |
| hs_hcnt_i | input | CNT_W | High-speed high count |
| hs_lcnt_i | input | CNT_W | High-speed low count |
| sda_hold_i | input | CNT_W | SDA hold after SCL fall, in clocks |
| req_i | input | 1 | Request valid |
| op_i | input | 2 | 0 none, 1 START, 2 BIT, 3 STOP |
| scl_i | input | 1 | Sampled SCL line level |
| ready_o | output | 1 | Idle, request can be accepted |
| scl_oe_o | output | 1 | Drive SCL low |
| sda_chg_o | output | 1 | SDA may change this cycle |
| done_o | output | 1 | Request completes this cycle |
| stretch_o | output | 1 | SCL held low by another device |
| hs_cap_o | output | 1 | High-speed mode implemented |

## Verification
The bench aims at the points where a cycle count is easily off by one. It checks the exact low-phase length and the high phase measured from SCL release. A design that started the high count on release rather than on the observed high level would finish early under stretching and under-count stretch_o. It also checks the hold strobe at index zero and its clamp to the last low cycle, the raising of too-small counts to the minimum, and the high-speed fallback on a build without that mode, which would otherwise run with the short high-speed counts. Finally, it changes counts in the middle of a request, and issues requests while busy or with no operation; a design that failed to capture or to ignore them would show a wrong length or a phase that should not start.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_BIT   = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } phase_e;

  localparam logic [1:0] SPD_STD  = 2'd1;
  localparam logic [1:0] SPD_FAST = 2'd2;
  localparam logic [1:0] SPD_HS   = 2'd3;
endpackage

// File: rtl/scl_cnt_sel.sv
module scl_cnt_sel #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6,
  parameter bit HS_CAP  = 1'b1
) (
  input  logic [1:0]       speed_i,
  input  logic [CNT_W-1:0] ss_hcnt_i,
  input  logic [CNT_W-1:0] ss_lcnt_i,
  input  logic [CNT_W-1:0] fs_hcnt_i,
  input  logic [CNT_W-1:0] fs_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o,
  output logic [CNT_W-1:0] hold_o
);
  import scl_timer_pkg::*;

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] raw_h, raw_l;
  logic             use_hs;

  function automatic logic [CNT_W-1:0] clamp_min(input logic [CNT_W-1:0] v);
    return (v < MIN_V) ? MIN_V : v;
  endfunction

  generate
    if (HS_CAP) begin : g_hs
      assign use_hs = (speed_i == SPD_HS);
    end else begin : g_no_hs
      assign use_hs = 1'b0;
    end
  endgenerate

  always_comb begin
    if (use_hs) begin
      raw_h = hs_hcnt_i;
      raw_l = hs_lcnt_i;
    end else if (speed_i == SPD_FAST || speed_i == SPD_HS) begin
      raw_h = fs_hcnt_i;
      raw_l = fs_lcnt_i;
    end else begin
      raw_h = ss_hcnt_i;
      raw_l = ss_lcnt_i;
    end
  end

  assign hcnt_o = clamp_min(raw_h);
  assign lcnt_o = clamp_min(raw_l);
  // strobe must land inside the low phase
  assign hold_o = (hold_i >= lcnt_o) ? lcnt_o - 1'b1 : hold_i;

  always_comb begin
    p_no_hs_r4: assert (HS_CAP || !use_hs);
    p_hold_in_low_r6: assert (hold_o < lcnt_o);
  end
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[i] <= 1'b1;
          else         ff_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[i] <= 1'b1;
          else         ff_q[i] <= ff_q[i-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scl_hold_timer.sv
module scl_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign strobe_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q    <= load_i;
      active_q <= 1'b1;
    end else if (strobe_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_single_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o && !arm_i |=> !strobe_o);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  scl_timer_pkg::op_e    op_i,
  input  logic [CNT_W-1:0]      hcnt_i,
  input  logic [CNT_W-1:0]      lcnt_i,
  input  logic                  scl_sync_i,
  output logic                  accept_o,
  output logic                  ready_o,
  output logic                  scl_oe_o,
  output logic                  done_o,
  output logic                  stop_edge_o,
  output logic                  stretch_o
);
  import scl_timer_pkg::*;

  localparam logic [CNT_W-1:0] SYNC_V = CNT_W'(SYNC_STAGES);
  localparam logic [CNT_W-1:0] WAIT_MAX = '1;

  phase_e           state_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q, hcnt_q, wait_q, low_run_q;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept_o    = ready_o && req_i && (op_i != OP_NONE);
  assign scl_oe_o    = (state_q == ST_LOW);
  assign done_o      = (state_q == ST_HIGH) && (cnt_q == '0);
  assign stop_edge_o = done_o && (op_q == OP_STOP);
  // released but still low after synchronizer latency
  assign stretch_o   = (state_q == ST_WAIT) && (wait_q > SYNC_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      hcnt_q  <= '0;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          op_q   <= op_i;
          hcnt_q <= hcnt_i;
          if (op_i == OP_START) begin
            state_q <= ST_HIGH;
            cnt_q   <= hcnt_i - 1'b1;
          end else begin
            state_q <= ST_LOW;
            cnt_q   <= lcnt_i - 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt_q == '0) begin
            state_q <= ST_WAIT;
            wait_q  <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (scl_sync_i) begin
            state_q <= ST_HIGH;
            cnt_q   <= hcnt_q - 1'b1;
          end else if (wait_q != WAIT_MAX) begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker-only run length of the low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_run_q <= '0;
    else if (state_q == ST_LOW) low_run_q <= low_run_q + 1'b1;
    else                        low_run_q <= '0;
  end

  p_min_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && cnt_q == '0) |-> (low_run_q >= CNT_W'(MIN_CNT - 1)));
  p_done_then_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  p_stretch_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |-> (!scl_oe_o && !ready_o && !done_o));
  p_idle_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !accept_o) |=> (ready_o && !scl_oe_o));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2,
  parameter bit HS_CAP      = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       speed_i,
  input  logic [CNT_W-1:0] ss_hcnt_i,
  input  logic [CNT_W-1:0] ss_lcnt_i,
  input  logic [CNT_W-1:0] fs_hcnt_i,
  input  logic [CNT_W-1:0] fs_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  input  logic [CNT_W-1:0] sda_hold_i,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic             scl_i,
  output logic             ready_o,
  output logic             scl_oe_o,
  output logic             sda_chg_o,
  output logic             done_o,
  output logic             stretch_o,
  output logic             hs_cap_o
);
  import scl_timer_pkg::*;

  logic [CNT_W-1:0] hcnt, lcnt, hold_eff, hold_load;
  logic             scl_sync, accept, stop_edge, hold_strobe;
  op_e              op;

  assign op       = op_e'(op_i);
  assign hs_cap_o = HS_CAP;

  scl_cnt_sel #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .HS_CAP(HS_CAP)) u_sel (
    .speed_i  (speed_i),
    .ss_hcnt_i(ss_hcnt_i), .ss_lcnt_i(ss_lcnt_i),
    .fs_hcnt_i(fs_hcnt_i), .fs_lcnt_i(fs_lcnt_i),
    .hs_hcnt_i(hs_hcnt_i), .hs_lcnt_i(hs_lcnt_i),
    .hold_i   (sda_hold_i),
    .hcnt_o   (hcnt), .lcnt_o(lcnt), .hold_o(hold_eff)
  );

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_sync)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_i       (op),
    .hcnt_i     (hcnt),
    .lcnt_i     (lcnt),
    .scl_sync_i (scl_sync),
    .accept_o   (accept),
    .ready_o    (ready_o),
    .scl_oe_o   (scl_oe_o),
    .done_o     (done_o),
    .stop_edge_o(stop_edge),
    .stretch_o  (stretch_o)
  );

  // START changes SDA at once while SCL is high
  assign hold_load = (op == OP_START) ? '0 : hold_eff;

  scl_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(accept), .load_i(hold_load),
    .strobe_o(hold_strobe)
  );

  assign sda_chg_o = hold_strobe | stop_edge;

  p_strobe_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_strobe |-> !ready_o);
  p_stop_edge_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_edge |-> (!scl_oe_o && done_o));
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ready_o && !scl_oe_o));
endmodule

// File: tb/scl_phase_timer_tb.sv
module scl_phase_timer_tb;
  import scl_timer_pkg::*;

  localparam int CNT_W = 16;
  localparam int SYNC  = 2;

  typedef struct packed {
    logic [1:0] spd;
    logic [7:0] hold;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] idx;
  } vec_t;

  // ss 20/24, fs 8/12, hs 3(->6)/7
  localparam vec_t VECS [6] = '{
    '{2'd1, 8'd0,  8'd24, 8'd20, 8'd0},
    '{2'd2, 8'd3,  8'd12, 8'd8,  8'd3},
    '{2'd3, 8'd2,  8'd7,  8'd6,  8'd2},
    '{2'd0, 8'd5,  8'd24, 8'd20, 8'd5},
    '{2'd2, 8'd50, 8'd12, 8'd8,  8'd11},
    '{2'd3, 8'd0,  8'd7,  8'd6,  8'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] speed = 2'd2;
  logic [CNT_W-1:0] ss_h = 16'd20, ss_l = 16'd24, fs_h = 16'd8, fs_l = 16'd12;
  logic [CNT_W-1:0] hs_h = 16'd3, hs_l = 16'd7, hold = 16'd0;
  logic req = 1'b0, req_nh = 1'b0;
  logic [1:0] op = 2'd0;
  logic stretch = 1'b0;
  logic scl_line, scl_nh;
  logic ready, scl_oe, sda_chg, done, stretch_o, hs_cap;
  logic ready_nh, oe_nh, sda_nh, done_nh, str_nh, cap_nh;

  int errors = 0, checks = 0, cyc = 0;
  int low_len, hi_len, hidx, str_cnt;
  bit first_str, stop_str;

  always #4 clk = ~clk;

  assign scl_line = ~scl_oe & ~stretch;
  assign scl_nh   = ~oe_nh;

  scl_phase_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .HS_CAP(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .speed_i(speed),
    .ss_hcnt_i(ss_h), .ss_lcnt_i(ss_l), .fs_hcnt_i(fs_h), .fs_lcnt_i(fs_l),
    .hs_hcnt_i(hs_h), .hs_lcnt_i(hs_l), .sda_hold_i(hold),
    .req_i(req), .op_i(op), .scl_i(scl_line),
    .ready_o(ready), .scl_oe_o(scl_oe), .sda_chg_o(sda_chg), .done_o(done),
    .stretch_o(stretch_o), .hs_cap_o(hs_cap)
  );

  scl_phase_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .HS_CAP(1'b0)) u_dut_nohs (
    .clk_i(clk), .rst_ni(rst_ni), .speed_i(speed),
    .ss_hcnt_i(ss_h), .ss_lcnt_i(ss_l), .fs_hcnt_i(fs_h), .fs_lcnt_i(fs_l),
    .hs_hcnt_i(hs_h), .hs_lcnt_i(hs_l), .sda_hold_i(hold),
    .req_i(req_nh), .op_i(op), .scl_i(scl_nh),
    .ready_o(ready_nh), .scl_oe_o(oe_nh), .sda_chg_o(sda_nh), .done_o(done_nh),
    .stretch_o(str_nh), .hs_cap_o(cap_nh)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic issue(input op_e o);
    @(negedge clk);
    req = 1'b1; op = o;
    @(negedge clk);
    req = 1'b0; op = OP_NONE;
  endtask

  task automatic measure(input int sn);
    bit fin;
    stretch = (sn > 0);
    low_len = 0; hidx = -1;
    while (scl_oe) begin
      if (sda_chg) hidx = low_len;
      low_len++;
      @(negedge clk);
    end
    hi_len = 0; str_cnt = 0; first_str = 0; stop_str = 0; fin = 0;
    while (!fin) begin
      hi_len++;
      if (stretch_o) str_cnt++;
      if (sda_chg && hi_len == 1) first_str = 1;
      if (done) begin
        stop_str = sda_chg;
        fin = 1;
      end else begin
        if (sn > 0 && hi_len == sn + 1) stretch = 1'b0;
        @(negedge clk);
      end
    end
    stretch = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 sda_chg", int'(sda_chg), 0);
    check("R1 done", int'(done), 0);
    check("R1 stretch", int'(stretch_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6 vector table
    foreach (VECS[i]) begin
      speed = VECS[i].spd;
      hold  = 16'(VECS[i].hold);
      issue(OP_BIT);
      measure(0);
      check($sformatf("R2 low len v%0d", i), low_len, int'(VECS[i].lo));
      check($sformatf("R3 high len v%0d", i), hi_len, int'(VECS[i].hi) + SYNC + 1);
      check($sformatf("R6 hold idx v%0d", i), hidx, int'(VECS[i].idx));
      check($sformatf("R7 no stretch v%0d", i), str_cnt, 0);
    end

    // R5 low count below minimum
    speed = 2'd1; ss_l = 16'd2; hold = 16'd0;
    issue(OP_BIT); measure(0);
    check("R5 clamp low", low_len, 6);
    ss_l = 16'd24;

    // R4 capability and fallback
    check("R4 cap hs", int'(hs_cap), 1);
    check("R4 cap nohs", int'(cap_nh), 0);
    speed = 2'd3;
    @(negedge clk); req_nh = 1'b1; op = OP_BIT;
    @(negedge clk); req_nh = 1'b0; op = OP_NONE;
    low_len = 0;
    while (oe_nh) begin low_len++; @(negedge clk); end
    hi_len = 1;
    while (!done_nh) begin hi_len++; @(negedge clk); end
    @(negedge clk);
    check("R4 fallback low", low_len, 12);
    check("R4 fallback high", hi_len, 8 + SYNC + 1);

    // R7 stretching
    speed = 2'd2; hold = 16'd0;
    issue(OP_BIT); measure(5);
    check("R7 stretched high", hi_len, 8 + SYNC + 1 + 5);
    check("R7 stretch cycles", str_cnt, 5);

    // R8 start
    issue(OP_START); measure(0);
    check("R8 start no low", low_len, 0);
    check("R8 start high", hi_len, 8);
    check("R8 start strobe", int'(first_str), 1);

    // R9 stop
    hold = 16'd3;
    issue(OP_STOP); measure(0);
    check("R9 stop low", low_len, 12);
    check("R9 stop hold idx", hidx, 3);
    check("R9 stop high", hi_len, 8 + SYNC + 1);
    check("R9 stop edge", int'(stop_str), 1);
    hold = 16'd0;

    // R10 mid-request change
    issue(OP_BIT);
    fs_l = 16'd30; fs_h = 16'd30; speed = 2'd1;
    measure(0);
    check("R10 latched low", low_len, 12);
    check("R10 latched high", hi_len, 8 + SYNC + 1);
    fs_l = 16'd12; fs_h = 16'd8; speed = 2'd2;

    // R11 op none at idle
    @(negedge clk); req = 1'b1; op = OP_NONE;
    @(negedge clk); req = 1'b0;
    check("R11 none ready", int'(ready), 1);
    check("R11 none scl", int'(scl_oe), 0);
    @(negedge clk);
    check("R11 none ready later", int'(ready), 1);

    // R11 request while busy
    issue(OP_BIT);
    req = 1'b1; op = OP_START;
    @(negedge clk);
    req = 1'b0; op = OP_NONE;
    measure(0);
    check("R11 busy low", low_len, 11);
    begin
      int act = 0;
      for (int k = 0; k < 4; k++) begin
        if (!ready || scl_oe || sda_chg) act++;
        @(negedge clk);
      end
      check("R11 busy ignored", act, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule